// File: doc/BRIEF.md
# Misaligned Fetch Group Aligner

This block stands between a small direct-mapped instruction cache and a four-wide decoder. The cache has eight lines of four instructions each. The block holds a fetch pointer whose two low bits pick a slot inside a line and whose next three bits pick the line. Each cycle it presents one fetch group of up to four instructions in program order, and it gives each decoder slot its own valid bit. The cache answers a line read in the same cycle that the index is driven, together with a hit flag.

When fetch starts part-way into a line, the block does not send that short group to the decoder. It spends one priming cycle copying the tail of the line into a leftover buffer. After that, every group is the buffered tail joined to the head of the next sequential line. Each new line refills the buffer with its own tail, so groups stay full across line boundaries. A redirect drops the buffer and restarts fetch at the new address in the next cycle. A cache miss stalls only the part of the group that the missing line would have supplied.

The controller has three states. ST_ALIGNED means the buffer is empty and the fetch pointer is on slot 0. ST_PRIME means the buffer is empty and the pointer is part-way into a line. ST_MERGE means the buffer holds leftovers. The transitions are as follows:
- prime_fill (ST_PRIME to ST_MERGE on a hit).
- merge_miss_drain (ST_MERGE to ST_ALIGNED when a miss cycle hands the leftovers to a ready decoder).
- redirect_aligned (any state to ST_ALIGNED when the redirect target is on slot 0).
- redirect_misaligned (any state to ST_PRIME when the redirect target is not on slot 0).
- A state holds in every other case.

Reset enters ST_ALIGNED at address 0.

Top module: `fetch_aligner`

## Requirements
- R1: In the first cycle after reset, rd_idx is 0, grp_pc is 0, and on a hit all four grp_valid bits are set.
- R2: In ST_ALIGNED on a hit, all four slots are valid. Slot i (grp_insn bits [i*32 +: 32]) carries the instruction at address grp_pc+i, and slot 0 is the oldest. Line slot j of rd_data holds the instruction whose address has low bits j.
- R3: A start address that is not on slot 0 gives one cycle with grp_valid 0 while the line tail is captured. The next group is full and starts at that address, with the tail in the oldest slots followed by the next line's head.
- R4: Each group taken by the decoder advances grp_pc by its number of valid slots. Successive merged groups are full and follow one another in address order.
- R5: The valid bits always form a run starting at slot 0, one of 0000, 0001, 0011, 0111 or 1111.
- R6: While dec_ready is low, or no slot is valid, grp_pc and the presented group do not change.
- R7: In a redirect cycle, no slot is valid. In the next cycle grp_pc equals the redirect target, with the leftover buffer emptied. An aligned target gives a full group in that cycle.
- R8: On a miss in ST_ALIGNED, no slot is valid, and rd_idx and grp_pc hold until the line hits.
- R9: On a miss in ST_MERGE, only the buffered leftovers are valid. Once they are taken, fetch resumes aligned at the same line.
- R10: The address wraps modulo 32, so the line after line 7 is line 0.
- R11: A miss in ST_PRIME presents nothing and retries the same line until it hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Flush the buffer and restart fetch at redir_pc |
| redir_pc | input | 5 | Redirect target, in instruction units |
| rd_idx | output | 3 | Cache line index being read |
| rd_data | input | 128 | Four instructions of the addressed line, slot 0 in the low bits |
| rd_hit | input | 1 | Tag hit for the addressed line |
| dec_ready | input | 1 | Decoder takes the presented group this cycle |
| grp_valid | output | 4 | Valid bit per decoder slot |
| grp_insn | output | 128 | Instructions per decoder slot, slot 0 oldest |
| grp_pc | output | 5 | Address of the instruction in slot 0 |

## Verification
A group is combinational from the line read. Its valid bits and contents are therefore due in the same cycle that the index, hit flag and ready are driven, and grp_pc moves one edge after a group is taken. A redirect shows its target one edge later. A misaligned start shows its first full group two edges later, after the priming cycle. The bench changes inputs just after the rising edge and samples outputs at the falling edge of that cycle, so every check falls in the cycle its result is due. The scoreboard queue holds the expected address and slot count of each group the decoder takes. Direct checks cover the empty cycles in which nothing is taken.

// File: rtl/faln_pkg.sv
package faln_pkg;
    typedef enum logic [1:0] {
        ST_ALIGNED = 2'd0,
        ST_PRIME   = 2'd1,
        ST_MERGE   = 2'd2
    } faln_state_e;
endpackage

// File: rtl/faln_ctrl.sv
module faln_ctrl
    import faln_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int LINES  = 8,
    parameter int RST_PC = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       redir_valid,
    input  logic [$clog2(WIDTH)+$clog2(LINES)-1:0] redir_pc,
    input  logic                       rd_hit,
    input  logic                       dec_ready,
    input  logic [$clog2(WIDTH)-1:0]   buf_cnt,
    output logic [$clog2(LINES)-1:0]   rd_idx,
    output logic [$clog2(WIDTH)+$clog2(LINES)-1:0] head_pc,
    output logic [$clog2(WIDTH):0]     nvalid,
    output logic                       buf_load,
    output logic                       buf_clear,
    output logic [$clog2(WIDTH)-1:0]   buf_src
);
    localparam int OFFW  = $clog2(WIDTH);
    localparam int LIDXW = $clog2(LINES);
    localparam int PCW   = OFFW + LIDXW;
    localparam int CNTW  = OFFW + 1;

    faln_state_e    state_q, state_d;
    logic [PCW-1:0] fpc_q, fpc_d;
    logic [PCW-1:0] head_q, head_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ALIGNED;
            fpc_q   <= PCW'(RST_PC);
            head_q  <= PCW'(RST_PC);
        end else begin
            state_q <= state_d;
            fpc_q   <= fpc_d;
            head_q  <= head_d;
        end
    end

    // next state and pointers
    always_comb begin
        state_d = state_q;
        fpc_d   = fpc_q;
        head_d  = head_q;
        unique case (state_q)
            ST_ALIGNED: begin
                if (rd_hit && dec_ready) begin
                    fpc_d  = fpc_q + PCW'(WIDTH);
                    head_d = head_q + PCW'(WIDTH);
                end
            end
            ST_PRIME: begin
                if (rd_hit) begin
                    // prime_fill: tail captured, pointer moves to next line head
                    fpc_d   = {fpc_q[PCW-1:OFFW] + LIDXW'(1), OFFW'(0)};
                    state_d = ST_MERGE;
                end
            end
            ST_MERGE: begin
                if (dec_ready) begin
                    if (rd_hit) begin
                        fpc_d  = fpc_q + PCW'(WIDTH);
                        head_d = head_q + PCW'(WIDTH);
                    end else begin
                        // merge_miss_drain: leftovers handed out alone
                        head_d  = head_q + PCW'(buf_cnt);
                        state_d = ST_ALIGNED;
                    end
                end
            end
            default: state_d = ST_ALIGNED;
        endcase
        if (redir_valid) begin
            fpc_d   = redir_pc;
            head_d  = redir_pc;
            state_d = (redir_pc[OFFW-1:0] == '0) ? ST_ALIGNED : ST_PRIME;
        end
    end

    // outputs
    always_comb begin
        nvalid    = '0;
        buf_load  = 1'b0;
        buf_clear = 1'b0;
        buf_src   = fpc_q[OFFW-1:0];
        unique case (state_q)
            ST_ALIGNED: begin
                nvalid = rd_hit ? CNTW'(WIDTH) : '0;
            end
            ST_PRIME: begin
                buf_load = rd_hit;
                buf_src  = fpc_q[OFFW-1:0];
            end
            ST_MERGE: begin
                nvalid    = rd_hit ? CNTW'(WIDTH) : {1'b0, buf_cnt};
                buf_load  = rd_hit && dec_ready;
                buf_src   = OFFW'(WIDTH - int'(buf_cnt));
                buf_clear = !rd_hit && dec_ready;
            end
            default: nvalid = '0;
        endcase
        if (redir_valid) begin
            nvalid    = '0;
            buf_load  = 1'b0;
            buf_clear = 1'b1;
        end
    end

    assign rd_idx  = fpc_q[PCW-1:OFFW];
    assign head_pc = head_q;
endmodule

// File: rtl/faln_buf.sv
module faln_buf #(
    parameter int WIDTH = 4,
    parameter int IW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic                         clear,
    input  logic [$clog2(WIDTH)-1:0]     src,
    input  logic [WIDTH*IW-1:0]          line,
    output logic [$clog2(WIDTH)-1:0]     cnt,
    output logic [(WIDTH-1)*IW-1:0]      ent
);
    localparam int OFFW  = $clog2(WIDTH);
    localparam int DEPTH = WIDTH - 1;

    logic [DEPTH*IW-1:0] ent_q, ent_d;
    logic [OFFW-1:0]     cnt_q;

    // copy line slots from src upward into entries 0..
    always_comb begin
        ent_d = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(src) + i < WIDTH) begin
                ent_d[i*IW +: IW] = line[(int'(src) + i)*IW +: IW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ent_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= OFFW'(WIDTH - int'(src));
            ent_q <= ent_d;
        end
    end

    assign cnt = cnt_q;
    assign ent = ent_q;
endmodule

// File: rtl/faln_merge.sv
module faln_merge #(
    parameter int WIDTH = 4,
    parameter int IW    = 32
) (
    input  logic [(WIDTH-1)*IW-1:0]  ent,
    input  logic [$clog2(WIDTH)-1:0] cnt,
    input  logic [WIDTH*IW-1:0]      line,
    input  logic [$clog2(WIDTH):0]   nvalid,
    output logic [WIDTH*IW-1:0]      slot_insn,
    output logic [WIDTH-1:0]         slot_valid
);
    logic [WIDTH*IW-1:0] ent_pad;
    assign ent_pad = {{IW{1'b0}}, ent};

    for (genvar g = 0; g < WIDTH; g++) begin : g_slot
        always_comb begin
            if (g < int'(cnt)) begin
                slot_insn[g*IW +: IW] = ent_pad[g*IW +: IW];
            end else begin
                slot_insn[g*IW +: IW] = line[(g - int'(cnt))*IW +: IW];
            end
        end
        assign slot_valid[g] = (g < int'(nvalid));
    end
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner #(
    parameter int WIDTH  = 4,
    parameter int LINES  = 8,
    parameter int IW     = 32,
    parameter int RST_PC = 0
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   redir_valid,
    input  logic [$clog2(WIDTH)+$clog2(LINES)-1:0] redir_pc,
    output logic [$clog2(LINES)-1:0]               rd_idx,
    input  logic [WIDTH*IW-1:0]                    rd_data,
    input  logic                                   rd_hit,
    input  logic                                   dec_ready,
    output logic [WIDTH-1:0]                       grp_valid,
    output logic [WIDTH*IW-1:0]                    grp_insn,
    output logic [$clog2(WIDTH)+$clog2(LINES)-1:0] grp_pc
);
    localparam int OFFW  = $clog2(WIDTH);
    localparam int CNTW  = OFFW + 1;
    localparam int DEPTH = WIDTH - 1;

    logic [OFFW-1:0]     buf_cnt;
    logic [DEPTH*IW-1:0] buf_ent;
    logic [CNTW-1:0]     nvalid;
    logic                buf_load;
    logic                buf_clear;
    logic [OFFW-1:0]     buf_src;

    faln_ctrl #(.WIDTH(WIDTH), .LINES(LINES), .RST_PC(RST_PC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .redir_valid(redir_valid),
        .redir_pc   (redir_pc),
        .rd_hit     (rd_hit),
        .dec_ready  (dec_ready),
        .buf_cnt    (buf_cnt),
        .rd_idx     (rd_idx),
        .head_pc    (grp_pc),
        .nvalid     (nvalid),
        .buf_load   (buf_load),
        .buf_clear  (buf_clear),
        .buf_src    (buf_src)
    );

    faln_buf #(.WIDTH(WIDTH), .IW(IW)) u_buf (
        .clk  (clk),
        .rst_n(rst_n),
        .load (buf_load),
        .clear(buf_clear),
        .src  (buf_src),
        .line (rd_data),
        .cnt  (buf_cnt),
        .ent  (buf_ent)
    );

    faln_merge #(.WIDTH(WIDTH), .IW(IW)) u_merge (
        .ent       (buf_ent),
        .cnt       (buf_cnt),
        .line      (rd_data),
        .nvalid    (nvalid),
        .slot_insn (grp_insn),
        .slot_valid(grp_valid)
    );
endmodule

// File: rtl/fetch_aligner_chk.sv
module fetch_aligner_chk #(
    parameter int WIDTH = 4,
    parameter int LINES = 8
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   redir_valid,
    input logic [$clog2(WIDTH)+$clog2(LINES)-1:0] redir_pc,
    input logic                                   rd_hit,
    input logic                                   dec_ready,
    input logic [WIDTH-1:0]                       grp_valid,
    input logic [$clog2(WIDTH)+$clog2(LINES)-1:0] grp_pc
);
    localparam int PCW = $clog2(WIDTH) + $clog2(LINES);

    AST_VALID_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp_valid + 1'b1) & grp_valid) == '0); // R5

    AST_REDIR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> grp_valid == '0); // R7

    AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> grp_pc == $past(redir_pc)); // R7

    AST_MISS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> !grp_valid[WIDTH-1]); // R8

    AST_HOLD_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && (!dec_ready || grp_valid == '0)) |=> $stable(grp_pc)); // R6

    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && dec_ready && grp_valid != '0)
        |=> (grp_pc - $past(grp_pc)) == PCW'($countones($past(grp_valid)))); // R4
endmodule

bind fetch_aligner fetch_aligner_chk #(.WIDTH(WIDTH), .LINES(LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .redir_valid(redir_valid),
    .redir_pc   (redir_pc),
    .rd_hit     (rd_hit),
    .dec_ready  (dec_ready),
    .grp_valid  (grp_valid),
    .grp_pc     (grp_pc)
);

// File: tb/sim_fetch_aligner.sv
`timescale 1ns/1ps
module sim_fetch_aligner;
    localparam int W  = 4;
    localparam int IW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          redir_valid = 1'b0;
    logic [4:0]    redir_pc = '0;
    logic [2:0]    rd_idx;
    logic [127:0]  rd_data;
    logic          rd_hit;
    logic          dec_ready = 1'b0;
    logic [3:0]    grp_valid;
    logic [127:0]  grp_insn;
    logic [4:0]    grp_pc;
    logic [7:0]    miss_mask = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct { int pc; int cnt; string req; } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    // cache model: instruction at address p is C0DE0000 | p
    always_comb begin
        for (int j = 0; j < W; j++) begin
            rd_data[j*IW +: IW] = 32'hC0DE_0000 | 32'({rd_idx, 2'(j)});
        end
        rd_hit = !miss_mask[rd_idx];
    end

    fetch_aligner u0 (
        .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_hit(rd_hit), .dec_ready(dec_ready),
        .grp_valid(grp_valid), .grp_insn(grp_insn), .grp_pc(grp_pc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int pc, input int cnt, input string req);
        exp_t e;
        e.pc = pc % 32; e.cnt = cnt; e.req = req;
        sb.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // monitor: every group the decoder takes is compared against the queue
    always @(negedge clk) begin
        if (rst_n && !redir_valid && dec_ready && grp_valid != '0) begin
            if (sb.size() == 0) begin
                check(1'b0, "R4", "unexpected group pc", int'(grp_pc), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(grp_pc) == e.pc, e.req, "group pc", int'(grp_pc), e.pc);
                check($countones(grp_valid) == e.cnt, e.req, "slot count",
                      $countones(grp_valid), e.cnt);
                for (int i = 0; i < e.cnt; i++) begin
                    int want;
                    want = 32'hC0DE_0000 | ((e.pc + i) % 32);
                    check(int'(grp_insn[i*IW +: IW]) == want, e.req, "slot insn",
                          int'(grp_insn[i*IW +: IW]), want);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(grp_valid == 4'hF, "R1", "valid after reset", grp_valid, 4'hF);
        check(grp_pc == 0, "R1", "pc after reset", grp_pc, 0);
        check(rd_idx == 0, "R1", "index after reset", rd_idx, 0);

        // aligned streaming with wrap past line 7
        tick();
        for (int k = 0; k < 9; k++) push(k * 4, 4, (k == 8) ? "R10" : "R2");
        dec_ready = 1'b1;
        repeat (9) tick();
        dec_ready = 1'b0;
        @(negedge clk);
        check(grp_pc == 4, "R10", "pc after wrap", grp_pc, 4);
        tick(); tick();
        @(negedge clk);
        check(grp_pc == 4, "R6", "pc held while not ready", grp_pc, 4);
        check(grp_valid == 4'hF, "R6", "group held while not ready", grp_valid, 4'hF);

        // misaligned redirect, priming, merged groups
        tick();
        redir_valid = 1'b1; redir_pc = 5'd9; dec_ready = 1'b1;
        @(negedge clk);
        check(grp_valid == 0, "R7", "valid in redirect cycle", grp_valid, 0);
        tick();
        redir_valid = 1'b0;
        @(negedge clk);
        check(grp_valid == 0, "R3", "valid in prime cycle", grp_valid, 0);
        check(rd_idx == 2, "R3", "prime line", rd_idx, 2);
        check(grp_pc == 9, "R7", "pc after redirect", grp_pc, 9);
        push(9, 4, "R3"); push(13, 4, "R4"); push(17, 4, "R4");
        repeat (4) tick();

        // miss while merging: only leftovers valid
        miss_mask[6] = 1'b1;
        push(21, 3, "R9");
        @(negedge clk);
        check(grp_valid == 4'b0111, "R9", "leftovers only", grp_valid, 4'b0111);
        tick();
        @(negedge clk);
        check(grp_valid == 0, "R8", "valid on aligned miss", grp_valid, 0);
        check(grp_pc == 24, "R9", "pc after drain", grp_pc, 24);
        check(rd_idx == 6, "R8", "index on miss", rd_idx, 6);
        tick();
        @(negedge clk);
        check(rd_idx == 6, "R8", "index held on miss", rd_idx, 6);
        push(24, 4, "R8");
        tick();
        miss_mask[6] = 1'b0;
        tick();
        dec_ready = 1'b0;

        // misaligned redirect into a missing line near the top
        redir_valid = 1'b1; redir_pc = 5'd30; miss_mask[7] = 1'b1; dec_ready = 1'b1;
        @(negedge clk);
        check(grp_valid == 0, "R7", "valid in redirect cycle", grp_valid, 0);
        tick();
        redir_valid = 1'b0;
        @(negedge clk);
        check(grp_valid == 0, "R11", "valid on prime miss", grp_valid, 0);
        check(rd_idx == 7, "R11", "prime line on miss", rd_idx, 7);
        tick();
        @(negedge clk);
        check(rd_idx == 7, "R11", "prime retries line", rd_idx, 7);
        check(grp_pc == 30, "R11", "pc held on prime miss", grp_pc, 30);
        push(30, 4, "R10"); push(2, 4, "R4");
        tick();
        miss_mask[7] = 1'b0;
        @(negedge clk);
        check(grp_valid == 0, "R3", "valid in prime hit cycle", grp_valid, 0);
        repeat (3) tick();

        // redirect while merging drops leftovers
        redir_valid = 1'b1; redir_pc = 5'd16;
        @(negedge clk);
        check(grp_valid == 0, "R7", "valid in redirect cycle", grp_valid, 0);
        push(16, 4, "R7");
        tick();
        redir_valid = 1'b0;
        @(negedge clk);
        check(grp_valid == 4'hF, "R7", "full group after aligned redirect", grp_valid, 4'hF);
        check(grp_pc == 16, "R7", "pc after aligned redirect", grp_pc, 16);
        tick();
        dec_ready = 1'b0;
        tick();
        check(sb.size() == 0, "R4", "groups left in queue", sb.size(), 0);
        finish_run();
    end
endmodule